// File: doc/BRIEF.md
# Lookahead Adder Subtractor

This block adds or subtracts two unsigned WIDTH-bit operands and presents the result and a carry-out from output registers. It is meant as a building block for an arithmetic unit. A single mode input selects the operation. In subtract mode the second operand is inverted bit by bit and the carry into the least significant bit is forced to 1. The result is therefore the two's-complement difference, and a carry-out of 1 means no borrow was needed.

The datapath is split into 4-bit slices. Each bit forms a generate term (both operand bits set), a propagate term (either operand bit set) and a half sum (the XOR of the two operand bits). Each slice derives its internal carries from fully expanded generate/propagate products and does not ripple. Each slice also reports a slice generate and a slice propagate. A second lookahead level turns these slice terms into every carry between slices, again in flattened form. Operands presented on one clock edge produce their result after that edge, and a new pair can be accepted on every cycle.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_en` = 0 sampled on a rising clock edge, `{carry_out, result}` after that edge equals the (WIDTH+1)-bit sum of `op_a` and `op_b`.
- R2: With `sub_en` = 1, `result` after the edge equals `op_a - op_b` modulo 2^WIDTH. `carry_out` is 1 exactly when `op_a >= op_b`, that is, when no borrow occurred.
- R3: Inside each 4-bit slice, the carry into bit i+1 equals g_i OR (p_i AND c_i). Here g_i = x_i AND y_i and p_i = x_i OR y_i, and y is the operand after the mode inversion. A carry that travels through low bits of a slice therefore reaches the correct bit.
- R4: Each result bit is 1 when an odd number of {x_i, y_i, c_i} are 1. Operands with no overlapping ones give their bitwise OR and carry_out 0.
- R5: A synchronous active-high `rst` drives `result` and `carry_out` to 0 on the next edge, whatever the operand and mode inputs are.
- R6: The carry into slice k+1 equals G_k OR (P_k AND carry into slice k). G_k and P_k are the slice generate and slice propagate. A carry produced in slice 0 therefore reaches the top bit and `carry_out`.
- R7: The result has exactly one cycle of latency. Operand pairs and modes that change on every cycle each produce their own correct result on the following cycle.
- R8: Subtracting equal operands gives result 0 with carry_out 1. Subtracting 1 from 0 gives all ones with carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Registered sum or difference |
| carry_out | output | 1 | Registered carry out of the top bit (1 = no borrow when subtracting) |

## Verification
There is no state apart from the output registers, so a fault in a slice's expanded carry terms or in the inter-slice lookahead shows up on `result` and `carry_out` one cycle after the operand pair that exercises it. Operand pairs that walk a carry through long runs of propagating bits expose faults in single product terms, which random pairs rarely hit. For this reason an 8-bit instance is checked against every operand pair in both modes. A 16-bit instance is driven with random pairs and with directed pairs that cross slice boundaries. A stuck mode inversion or a wrong forced carry-in shows up at once as a difference that is off by one or a sum in the wrong mode.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } slice_gp_t;
endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] half
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = x[i] & y[i];
    assign prop[i] = x[i] | y[i];
    assign half[i] = x[i] ^ y[i];
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [SLICE_W-1:0] gen,
  input  logic [SLICE_W-1:0] prop,
  input  logic [SLICE_W-1:0] half,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output slice_gp_t          sgp
);
  logic [SLICE_W-1:0] c;

  assign c[0] = cin;
  assign c[1] = gen[0] | (prop[0] & cin);
  assign c[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin);
  assign c[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
              | (prop[2] & prop[1] & prop[0] & cin);

  assign sgp.gen  = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                  | (prop[3] & prop[2] & prop[1] & gen[0]);
  assign sgp.prop = &prop;

  assign sum = half ^ c;

  // Expanded carries checked against a step-by-step ripple of the same terms.
  always_comb begin
    logic r;
    r = cin;
    if (!$isunknown({gen, prop, half, cin})) begin
      for (int i = 0; i < SLICE_W; i++) begin
        AST_SLICE_CARRY: assert (c[i] == r); // R3
        AST_HALF_SUM: assert (half[i] == (prop[i] & ~gen[i])); // R4
        r = gen[i] | (prop[i] & r);
      end
      AST_SLICE_OUT: assert (r == (sgp.gen | (sgp.prop & cin))); // R6
    end
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int NSLICE = 4
) (
  input  logic [NSLICE-1:0] sgen,
  input  logic [NSLICE-1:0] sprop,
  input  logic              c0,
  output logic [NSLICE:0]   scarry
);
  // Flattened carry into slice k: any lower slice generating, with every
  // slice between it and k propagating, or c0 passing through all of them.
  function automatic logic flat_carry(input int k, input logic [NSLICE-1:0] gg,
                                      input logic [NSLICE-1:0] pp, input logic cz);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < NSLICE; j++) begin
      if (j < k) begin
        term = gg[j];
        for (int m = 0; m < NSLICE; m++)
          if (m > j && m < k) term = term & pp[m];
        acc = acc | term;
      end
    end
    term = cz;
    for (int m = 0; m < NSLICE; m++)
      if (m < k) term = term & pp[m];
    return acc | term;
  endfunction

  for (genvar k = 0; k <= NSLICE; k++) begin : g_carry
    assign scarry[k] = flat_carry(k, sgen, sprop, c0);
  end

  always_comb begin
    logic r;
    r = c0;
    if (!$isunknown({sgen, sprop, c0})) begin
      for (int k = 0; k <= NSLICE; k++) begin
        AST_INTER_SLICE: assert (scarry[k] == r); // R6
        if (k < NSLICE) r = sgen[k] | (sprop[k] & r);
      end
    end
  end
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int NSLICE = WIDTH / SLICE_W;

  logic [WIDTH-1:0]  y_eff;
  logic [WIDTH-1:0]  gen, prop, half;
  logic [WIDTH-1:0]  sum_c;
  logic [NSLICE-1:0] sgen, sprop;
  logic [NSLICE:0]   scarry;

  assign y_eff = op_b ^ {WIDTH{sub_en}};

  cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .x(op_a), .y(y_eff), .gen(gen), .prop(prop), .half(half)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    slice_gp_t sgp;
    cla_slice u_slice (
      .gen (gen [s*SLICE_W +: SLICE_W]),
      .prop(prop[s*SLICE_W +: SLICE_W]),
      .half(half[s*SLICE_W +: SLICE_W]),
      .cin (scarry[s]),
      .sum (sum_c[s*SLICE_W +: SLICE_W]),
      .sgp (sgp)
    );
    assign sgen[s]  = sgp.gen;
    assign sprop[s] = sgp.prop;
  end

  cla_lookahead #(.NSLICE(NSLICE)) u_la (
    .sgen(sgen), .sprop(sprop), .c0(sub_en), .scarry(scarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= sum_c;
      carry_out <= scarry[NSLICE];
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (result == '0 && carry_out == 1'b0)); // R5
  AST_ADD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sub_en) |=> ({carry_out, result} ==
      ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}))); // R1
  AST_SUB_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!rst && sub_en) |=> (result == WIDTH'($past(op_a) - $past(op_b)))); // R2
  AST_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
    (!rst && sub_en) |=> (carry_out == ($past(op_a) >= $past(op_b)))); // R2
endmodule

// File: tb/cla_addsub_tb.sv
`timescale 1ns/1ps
module cla_addsub_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a16 = '0, b16 = '0;
  logic        s16 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        s8 = 1'b0;
  logic [15:0] r16;
  logic        c16;
  logic [7:0]  r8;
  logic        c8;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [16:0] q16_exp[$];
  int          q16_cyc[$];
  string       q16_tag[$];
  logic [8:0]  q8_exp[$];
  int          q8_cyc[$];
  string       q8_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cla_addsub #(.WIDTH(16)) u_dut (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .sub_en(s16),
    .result(r16), .carry_out(c16)
  );
  cla_addsub #(.WIDTH(8)) u_dut_w8 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sub_en(s8),
    .result(r8), .carry_out(c8)
  );

  function automatic logic [16:0] ref16(input logic [15:0] a, input logic [15:0] b, input logic s);
    if (!s) return {1'b0, a} + {1'b0, b};
    return {(a >= b), 16'(a - b)};
  endfunction

  function automatic logic [8:0] ref8(input logic [7:0] a, input logic [7:0] b, input logic s);
    if (!s) return {1'b0, a} + {1'b0, b};
    return {(a >= b), 8'(a - b)};
  endfunction

  task automatic drive(input logic [15:0] xa, input logic [15:0] xb, input logic xs, input string t16,
                       input logic [7:0] ya, input logic [7:0] yb, input logic ys, input string t8);
    @(posedge clk);
    #1;
    a16 = xa; b16 = xb; s16 = xs;
    a8 = ya; b8 = yb; s8 = ys;
    q16_exp.push_back(ref16(xa, xb, xs)); q16_cyc.push_back(cyc + 1); q16_tag.push_back(t16);
    q8_exp.push_back(ref8(ya, yb, ys));   q8_cyc.push_back(cyc + 1);  q8_tag.push_back(t8);
  endtask

  // Monitor: pop and compare each expected item once its capture edge has passed.
  always @(negedge clk) begin
    if (q16_cyc.size() > 0 && cyc >= q16_cyc[0]) begin
      logic [16:0] e;
      string t;
      e = q16_exp.pop_front(); void'(q16_cyc.pop_front()); t = q16_tag.pop_front();
      total++;
      if ({c16, r16} !== e) begin
        bad++;
        $display("FAIL %s w16: got %h expected %h", t, {c16, r16}, e);
      end
    end
    if (q8_cyc.size() > 0 && cyc >= q8_cyc[0]) begin
      logic [8:0] e;
      string t;
      e = q8_exp.pop_front(); void'(q8_cyc.pop_front()); t = q8_tag.pop_front();
      total++;
      if ({c8, r8} !== e) begin
        bad++;
        $display("FAIL %s w8: got %h expected %h", t, {c8, r8}, e);
      end
    end
  end

  task automatic check_reset(input string t);
    total++;
    if ({c16, r16} !== 17'h0 || {c8, r8} !== 9'h0) begin
      bad++;
      $display("FAIL %s: got %h/%h expected 0/0", t, {c16, r16}, {c8, r8});
    end
  endtask

  initial begin
    // R5: reset with non-zero operands held on the inputs
    a16 = 16'hFFFF; b16 = 16'h0001; a8 = 8'hFF; b8 = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("R5 initial reset");

    // R1 R2 R7: exhaustive 8-bit in both modes, mode alternating every cycle;
    // random 16-bit alongside
    for (int xa = 0; xa < 256; xa++) begin
      for (int xb = 0; xb < 256; xb++) begin
        for (int m = 0; m < 2; m++) begin
          if (xa == 0 && xb == 0 && m == 0) begin
            @(posedge clk); #1; rst = 1'b0;
            a16 = 16'($urandom); b16 = 16'($urandom); s16 = 1'b0;
            a8 = 8'(xa); b8 = 8'(xb); s8 = 1'b0;
            q16_exp.push_back(ref16(a16, b16, 1'b0)); q16_cyc.push_back(cyc + 1); q16_tag.push_back("R1 random add");
            q8_exp.push_back(ref8(a8, b8, 1'b0)); q8_cyc.push_back(cyc + 1); q8_tag.push_back("R1 exhaustive add");
          end else begin
            drive(16'($urandom), 16'($urandom), m[0], (m == 0) ? "R1 random add" : "R2 random sub",
                  8'(xa), 8'(xb), m[0], (m == 0) ? "R1 exhaustive add" : "R2 exhaustive sub");
          end
        end
      end
    end

    // Directed 16-bit corners
    drive(16'hFFFF, 16'h0001, 1'b0, "R6 carry through all slices", 8'hFF, 8'h01, 1'b0, "R6 w8 wrap");
    drive(16'h0FFF, 16'h0001, 1'b0, "R6 carry into top slice",     8'h0F, 8'h01, 1'b0, "R6 w8 slice cross");
    drive(16'h0007, 16'h0001, 1'b0, "R3 carry inside slice",       8'h07, 8'h01, 1'b0, "R3 w8 in slice");
    drive(16'h5555, 16'hAAAA, 1'b0, "R4 no carries",               8'h55, 8'hAA, 1'b0, "R4 w8 no carries");
    drive(16'h1234, 16'h1234, 1'b1, "R8 equal subtract",           8'h3C, 8'h3C, 1'b1, "R8 w8 equal");
    drive(16'h0000, 16'h0001, 1'b1, "R8 zero minus one",           8'h00, 8'h01, 1'b1, "R8 w8 zero minus one");
    drive(16'h8000, 16'h7FFF, 1'b1, "R2 borrow chain",             8'h80, 8'h7F, 1'b1, "R2 w8 borrow chain");
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R1 max add",                  8'hFF, 8'hFF, 1'b0, "R1 w8 max add");
    for (int k = 0; k < 8; k++)
      drive(16'(k * 16'h1111), 16'hF0F1, k[0], "R7 back to back", 8'(k * 8'h23), 8'hC5, ~k[0], "R7 w8 back to back");

    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1; a16 = 16'hFFFF; b16 = 16'h0001; s16 = 1'b0; a8 = 8'h00; b8 = 8'h01; s8 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset("R5 reset after traffic");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule